// File: doc/BRIEF.md
# Programmable Edge Delay Generator

This block holds back the transitions of an asynchronous input by a programmable number of clock periods before they reach its output. A two-bit mode code picks which polarity is held back: rising transitions, falling transitions, both, or neither. A transition that is not held back is copied as soon as the synchronised input shows it. Delayed transitions are timed by an 8-bit down-counter that is loaded from the delay value.

An input that returns to its old level before the count runs out is never seen at the output, so the block also serves as a deglitcher. A two-flop synchroniser sits in front of the counter and adds two periods to every path. A control input can bypass it when the source is already synchronous to the clock. A busy output shows that a count is in progress.

Top module: `edge_dly`

## Requirements
- R1: A low `rst_n` sampled at a rising clock edge clears the synchroniser, the counter, `dout` and `busy` to 0, whatever `din` is.
- R2: `edge_sel` is decoded as 2'b00 = no delay on either polarity, 2'b01 = delay rising transitions only, 2'b10 = delay falling transitions only, 2'b11 = delay both. The first clock edge that samples a new `din` level is called the capture edge. With `sync_bypass` = 0, each latency below gains 2 clock periods over the bypassed value.
- R3: A transition that is not delayed appears on `dout` 2 clock periods after the capture edge. With `sync_bypass` = 1 it appears at the capture edge itself.
- R4: A delayed transition appears on `dout` `dly_val` + 2 clock periods after the capture edge when `sync_bypass` = 0.
- R5: With `sync_bypass` = 1, a delayed transition appears on `dout` exactly `dly_val` clock periods after the capture edge.
- R6: Rising and falling transitions are treated independently. In a single-polarity mode the other polarity follows the R3 latency, and `dout` only ever changes to the current synchronised input level.
- R7: A new level that is sampled on `dly_val` or fewer consecutive edges before reverting leaves `dout` unchanged. A level held for `dly_val` + 1 samples passes.
- R8: When the input reverts during a count, the count is dropped. A later transition starts a fresh count of the full `dly_val`, without resuming the earlier one.
- R9: With `dly_val` = 0, a delayed transition has the same latency as a transition that is not delayed.
- R10: `busy` goes to 1 at the edge that starts a count. It goes to 0 at the edge where `dout` takes the new level or where the count is dropped. `dout` does not change while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| din | input | 1 | Asynchronous input to be delayed |
| dly_val | input | 8 | Delay in clock periods |
| edge_sel | input | 2 | Polarity selection code (see R2) |
| sync_bypass | input | 1 | 1 = skip the two-flop input synchroniser |
| dout | output | 1 | Delayed output |
| busy | output | 1 | A delay count is in progress |

## Verification
The bench measures the exact edge on which `dout` moves in every mode, with the synchroniser in use and bypassed. An off-by-one in the counter load or the terminal test would shift each of those edges by one period. It sends pulses one sample shorter than the delay and exactly long enough. A design that compares against the wrong count would either leak the short glitch or eat the valid pulse. It interrupts a count and retriggers it: a design that resumed the old count would produce the edge too early. It also checks that an unselected polarity is not held back and that a zero delay collapses to the plain path.

// File: rtl/edge_dly_pkg.sv
// Package: shared types for the edge delay generator.
// Assumes the mode code layout of the top-level edge_sel input.
package edge_dly_pkg;

    // Polarity selection; bit 0 enables rising delay, bit 1 falling delay.
    typedef enum logic [1:0] {
        MODE_NONE = 2'b00,
        MODE_RISE = 2'b01,
        MODE_FALL = 2'b10,
        MODE_BOTH = 2'b11
    } edge_mode_e;

    // True when a transition toward new_lvl must be held back in this mode.
    function automatic logic needs_delay(edge_mode_e mode, logic new_lvl);
        logic [1:0] m;
        m = mode;
        return new_lvl ? m[0] : m[1];
    endfunction

endpackage

// File: rtl/edge_dly_sync.sv
// Module: edge_dly_sync
// Multi-stage input synchroniser with a run-time bypass.
// Assumes STAGES >= 1; the bypass path is combinational and is intended
// only for inputs already synchronous to clk.
module edge_dly_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic bypass,
    output logic lvl
);

    logic [STAGES-1:0] chain_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // First flop samples the raw asynchronous input.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[0] <= 1'b0;
                else        chain_q[0] <= din;
            end
        end else begin : g_next
            // Later flops resolve metastability of the stage before.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[i] <= 1'b0;
                else        chain_q[i] <= chain_q[i-1];
            end
        end
    end

    // Select raw input or last synchroniser stage.
    always_comb begin
        lvl = bypass ? din : chain_q[STAGES-1];
    end

endmodule

// File: rtl/edge_dly_cnt.sv
// Module: edge_dly_cnt
// Loadable down-counter that times one delay window.
// Assumes the controller never asserts load and step together; clear wins.
module edge_dly_cnt #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             load,
    input  logic             step,
    input  logic [WIDTH-1:0] load_val,
    output logic [WIDTH-1:0] count,
    output logic             last
);

    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    logic [WIDTH-1:0] cnt_q;

    // Counter register: clear, load or decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (clear) cnt_q <= '0;
        else if (load)  cnt_q <= load_val;
        else if (step)  cnt_q <= cnt_q - ONE;
    end

    // Terminal flag: the current edge is the final one of the window.
    always_comb begin
        count = cnt_q;
        last  = (cnt_q == ONE);
    end

endmodule

// File: rtl/edge_dly_ctrl.sv
// Module: edge_dly_ctrl
// Output and busy state machine: decides for each pending transition
// whether to pass it, start a count, keep counting, finish or drop it.
// Assumes lvl is already synchronous to clk.
module edge_dly_ctrl
    import edge_dly_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lvl,
    input  edge_mode_e mode,
    input  logic       zero_dly,
    input  logic       cnt_last,
    output logic       dout,
    output logic       busy,
    output logic       cnt_clear,
    output logic       cnt_load,
    output logic       cnt_step
);

    logic dout_q, dout_d;
    logic busy_q, busy_d;
    logic pending;
    logic hold;

    // Classify the current input against the output.
    always_comb begin
        pending = (lvl != dout_q);
        hold    = needs_delay(mode, lvl);
    end

    // Next-state decision for output, busy and counter controls.
    always_comb begin
        dout_d    = dout_q;
        busy_d    = busy_q;
        cnt_clear = 1'b0;
        cnt_load  = 1'b0;
        cnt_step  = 1'b0;
        if (!pending) begin
            busy_d    = 1'b0;
            cnt_clear = busy_q;
        end else if (!hold) begin
            dout_d    = lvl;
            busy_d    = 1'b0;
            cnt_clear = busy_q;
        end else if (!busy_q) begin
            if (zero_dly) begin
                dout_d = lvl;
            end else begin
                cnt_load = 1'b1;
                busy_d   = 1'b1;
            end
        end else if (cnt_last) begin
            dout_d    = lvl;
            busy_d    = 1'b0;
            cnt_clear = 1'b1;
        end else begin
            cnt_step = 1'b1;
        end
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q <= 1'b0;
            busy_q <= 1'b0;
        end else begin
            dout_q <= dout_d;
            busy_q <= busy_d;
        end
    end

    // Drive the outputs from the registers.
    always_comb begin
        dout = dout_q;
        busy = busy_q;
    end

endmodule

// File: rtl/edge_dly.sv
// Module: edge_dly (top)
// Programmable edge delay generator: synchroniser, down-counter and
// controller. Assumes din may be asynchronous unless sync_bypass is set.
module edge_dly
    import edge_dly_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din,
    input  logic [CNT_W-1:0] dly_val,
    input  logic [1:0]       edge_sel,
    input  logic             sync_bypass,
    output logic             dout,
    output logic             busy
);

    logic             sync_lvl;
    logic [CNT_W-1:0] cnt_val;
    logic             cnt_last;
    logic             cnt_clear;
    logic             cnt_load;
    logic             cnt_step;
    logic             zero_dly;
    edge_mode_e       mode;

    // Decode configuration inputs.
    always_comb begin
        mode     = edge_mode_e'(edge_sel);
        zero_dly = (dly_val == '0);
    end

    edge_dly_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (din),
        .bypass (sync_bypass),
        .lvl    (sync_lvl)
    );

    edge_dly_cnt #(
        .WIDTH (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (cnt_clear),
        .load     (cnt_load),
        .step     (cnt_step),
        .load_val (dly_val),
        .count    (cnt_val),
        .last     (cnt_last)
    );

    edge_dly_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl       (sync_lvl),
        .mode      (mode),
        .zero_dly  (zero_dly),
        .cnt_last  (cnt_last),
        .dout      (dout),
        .busy      (busy),
        .cnt_clear (cnt_clear),
        .cnt_load  (cnt_load),
        .cnt_step  (cnt_step)
    );

endmodule

// File: rtl/edge_dly_chk.sv
// Module: edge_dly_chk
// Property checker for edge_dly, attached through bind.
module edge_dly_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             din,
    input logic [1:0]       edge_sel,
    input logic             sync_bypass,
    input logic             dout,
    input logic             busy,
    input logic             sync_lvl,
    input logic [CNT_W-1:0] cnt_val
);

    // R1: reset clears output and busy.
    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (!dout && !busy));

    // R3: bypassed, undelayed input reaches dout at the capture edge.
    assert_bypass_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_sel == 2'b00 && sync_bypass) |=> (dout == $past(din)));

    // R6: dout only moves to the synchronised input level.
    assert_moves_to_input_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dout) |-> (dout == $past(sync_lvl)));

    // R10: output frozen while a count is in progress.
    assert_hold_while_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> $stable(dout));

    // R4: a live count never sits at zero.
    assert_count_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt_val != '0));

endmodule

bind edge_dly edge_dly_chk #(.CNT_W(CNT_W)) u_edge_dly_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .din         (din),
    .edge_sel    (edge_sel),
    .sync_bypass (sync_bypass),
    .dout        (dout),
    .busy        (busy),
    .sync_lvl    (sync_lvl),
    .cnt_val     (cnt_val)
);

// File: tb/edge_dly_bench.sv
// Directed bench for edge_dly; drives at falling edges, samples 2 ns after rising edges.
module edge_dly_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       din;
    logic [7:0] dly_val;
    logic [1:0] edge_sel;
    logic       sync_bypass;
    logic       dout;
    logic       busy;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    edge_dly u_edge_dly (
        .clk         (clk),
        .rst_n       (rst_n),
        .din         (din),
        .dly_val     (dly_val),
        .edge_sel    (edge_sel),
        .sync_bypass (sync_bypass),
        .dout        (dout),
        .busy        (busy)
    );

    task automatic chk(input logic act, input logic exp, input string req, input string what);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic sample();
        @(posedge clk);
        #2;
    endtask

    // Change din and check dout moves exactly lat periods after capture edge.
    task automatic edge_test(input logic v, input int lat, input string req);
        @(negedge clk);
        din = v;
        for (int j = 0; j <= lat; j++) begin
            sample();
            chk(dout, (j < lat) ? ~v : v, req, "dout latency");
        end
    endtask

    task automatic cfg(input logic [1:0] m, input logic [7:0] d, input logic byp);
        @(negedge clk);
        edge_sel    = m;
        dly_val     = d;
        sync_bypass = byp;
        repeat (4) @(posedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; din = 1'b1; edge_sel = 2'b00; dly_val = 8'd0; sync_bypass = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        chk(dout, 1'b0, "R1", "dout in reset");
        chk(busy, 1'b0, "R1", "busy in reset");
        @(negedge clk);
        din = 1'b0;
        rst_n = 1'b1;
        repeat (4) @(posedge clk);
        #2;
        chk(dout, 1'b0, "R1", "dout after reset");
    endtask

    task automatic t_pass();
        cfg(2'b00, 8'd9, 1'b0);
        edge_test(1'b1, 2, "R3");
        edge_test(1'b0, 2, "R3");
        cfg(2'b00, 8'd9, 1'b1);
        edge_test(1'b1, 0, "R3");
        edge_test(1'b0, 0, "R2");
    endtask

    task automatic t_rise_only();
        cfg(2'b01, 8'd5, 1'b0);
        edge_test(1'b1, 7, "R4");
        edge_test(1'b0, 2, "R6");
    endtask

    task automatic t_fall_only();
        cfg(2'b10, 8'd3, 1'b0);
        edge_test(1'b1, 2, "R6");
        edge_test(1'b0, 5, "R2");
    endtask

    task automatic t_both_bypass();
        cfg(2'b11, 8'd4, 1'b1);
        edge_test(1'b1, 4, "R5");
        edge_test(1'b0, 4, "R5");
    endtask

    task automatic t_filter();
        cfg(2'b11, 8'd4, 1'b1);
        @(negedge clk);
        din = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        din = 1'b0;
        for (int j = 0; j < 8; j++) begin
            sample();
            chk(dout, 1'b0, "R7", "short pulse filtered");
        end
        edge_test(1'b1, 4, "R7");
        edge_test(1'b0, 4, "R7");
    endtask

    task automatic t_restart();
        cfg(2'b01, 8'd6, 1'b1);
        @(negedge clk);
        din = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        din = 1'b0;
        sample();
        chk(busy, 1'b0, "R8", "busy dropped on revert");
        chk(dout, 1'b0, "R8", "dout held on revert");
        edge_test(1'b1, 6, "R8");
        edge_test(1'b0, 0, "R8");
    endtask

    task automatic t_zero();
        cfg(2'b11, 8'd0, 1'b0);
        edge_test(1'b1, 2, "R9");
        edge_test(1'b0, 2, "R9");
        cfg(2'b11, 8'd0, 1'b1);
        edge_test(1'b1, 0, "R9");
        edge_test(1'b0, 0, "R9");
    endtask

    task automatic t_busy();
        cfg(2'b01, 8'd3, 1'b0);
        @(negedge clk);
        din = 1'b1;
        for (int j = 0; j <= 5; j++) begin
            sample();
            chk(busy, (j >= 2 && j <= 4) ? 1'b1 : 1'b0, "R10", "busy window");
            chk(dout, (j >= 5) ? 1'b1 : 1'b0, "R10", "dout during count");
        end
        edge_test(1'b0, 2, "R10");
    endtask

    initial begin
        t_reset();
        t_pass();
        t_rise_only();
        t_fall_only();
        t_both_bypass();
        t_filter();
        t_restart();
        t_zero();
        t_busy();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule